// File: doc/BRIEF.md
# Warp Matrix Fragment Store Unit

This block takes the register fragments that the 32 lanes of a warp hold for one to four small matrices and turns them into whole-row store requests for a banked scratchpad memory. A single start pulse captures every lane's source registers and row address, together with qualifiers for shape, matrix count, transpose and element width. The block then rebuilds each 16-byte matrix row, or each column when the transpose qualifier is set, from the lanes that hold its pieces. It sends that row to a ready/valid write port at an address taken from one specific lane.

Two shapes are supported. The 8x8 shape uses 16-bit elements, and groups of four neighbouring lanes together hold one row. The 16x8 shape uses 8-bit elements packed four to a register, is always written transposed, and each pair of lanes holds one row of the fragment grid. The block rejects qualifier combinations that are not allowed and performs no writes for them. It skips any row whose address is not 16-byte aligned and flags that row. The caller sees `busy` for the whole operation and a `done` pulse when it ends.

The controller has four states. IDLE waits for work. CHECK spends one cycle validating the captured qualifiers. ISSUE walks the write slots. FINISH raises `done`. The transitions are:
- IDLE to CHECK when a start pulse is accepted.
- CHECK to ISSUE when the qualifiers are legal.
- CHECK to FINISH when they are illegal.
- ISSUE to ISSUE while slots remain or the port stalls.
- ISSUE to FINISH when the last slot retires.
- FINISH to IDLE unconditionally.

Top module: `warp_frag_store`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. It captures all lane registers, lane addresses and qualifiers. `busy` then stays high until the cycle after `done`. A `start` asserted while `busy` is high has no effect on the operation in flight.
- R2: `count_sel` encodes the matrix count: 2'b00 means one matrix, 2'b01 means two and 2'b10 means four. Each matrix produces 8 write slots. Slots are issued in order from matrix 0 slot 0 to the last slot of the last matrix. Slot k of matrix m is written to the address held by lane 8m+k.
- R3: For the 8x8 shape without transpose, the write for row k of matrix m is the concatenation of register m of lanes 4k, 4k+1, 4k+2 and 4k+3, with lane 4k in bits 31:0. Register m of lane l sits at bits [(4l+m)*32 +: 32] of `lane_regs`. Within a register, bits 15:0 hold the even column and bits 31:16 hold the next column.
- R4: For the 8x8 shape with transpose, write k of matrix m carries column k. Bits [16r +: 16] hold the element at row r and column k, which comes from register m of lane 4r + k/2.
- R5: For the 16x8 shape, write k of matrix m carries column k of a 16-row grid. Bits [8r +: 8] hold the byte from register m of lane 2r + k/4, at byte position k%4. Byte e0 is bits 7:0 and byte e3 is bits 31:24.
- R6: The following combinations are illegal: `shape_16x8`=1 without both `elem_8bit`=1 and `transpose`=1, `shape_16x8`=0 with `elem_8bit`=1, and `count_sel`=2'b11. For any of them the block makes no writes, and `err_illegal` is high in the same cycle as `done`.
- R7: A slot whose lane address has any of bits 3:0 set issues no write. `err_misalign` pulses for one cycle for that slot, and the remaining slots still proceed.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady into the next cycle.
- R9: `done` is a one-cycle pulse that follows the final accepted write or skipped slot. After it, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current inputs |
| shape_16x8 | input | 1 | 1 selects the 16x8 shape, 0 selects 8x8 |
| count_sel | input | 2 | Matrix count code (00 one, 01 two, 10 four) |
| transpose | input | 1 | Write columns instead of rows |
| elem_8bit | input | 1 | 1 selects 8-bit elements, 0 selects 16-bit |
| lane_regs | input | 32*4*32 | Four 32-bit source registers per lane |
| lane_addrs | input | 32*ADDR_W | Row start address per lane |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory port accepts the write |
| wr_addr | output | ADDR_W | Byte address of the row being written |
| wr_data | output | 128 | Sixteen bytes of row or column data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_illegal | output | 1 | Qualifier combination rejected (with `done`) |
| err_misalign | output | 1 | Current slot skipped for misalignment |

## Verification
The bench builds the block with its default 16-bit address width. This width is enough to give every lane a distinct, non-contiguous aligned row address, so a lane-to-slot mixup shows up as a wrong address. Across runs the bench covers all three matrix counts on both shapes, with and without transpose. This exercises every lane's registers, including register 3 of lanes 24 to 31, in the x4 cases. The memory port's ready signal alternates between always-high and a pseudo-random stall pattern, which exercises the hold behaviour in the middle of a row sequence. Seeded misaligned lanes and a start pulse that arrives during an x4 run cover the skip and ignore paths.

// File: rtl/wfs_pkg.sv
package wfs_pkg;

    localparam int LANES         = 32;
    localparam int MAX_MATS      = 4;
    localparam int REG_W         = 32;
    localparam int SLOTS_PER_MAT = 8;
    localparam int ROW_BYTES     = 16;
    localparam int ROW_W         = ROW_BYTES * 8;
    localparam int SLOT_W        = $clog2(MAX_MATS * SLOTS_PER_MAT);
    localparam int REGS_W        = LANES * MAX_MATS * REG_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_FINISH
    } wfs_state_e;

    typedef struct packed {
        logic       shape_wide;
        logic [1:0] count_code;
        logic       transpose;
        logic       elem_byte;
    } wfs_qual_t;

    function automatic logic qual_legal(input wfs_qual_t q);
        logic shape_ok;
        shape_ok = q.shape_wide ? (q.elem_byte && q.transpose) : !q.elem_byte;
        return shape_ok && (q.count_code != 2'b11);
    endfunction

    function automatic logic [SLOT_W:0] slot_total(input logic [1:0] code);
        logic [SLOT_W:0] n;
        unique case (code)
            2'b00:   n = (SLOT_W+1)'(SLOTS_PER_MAT);
            2'b01:   n = (SLOT_W+1)'(2 * SLOTS_PER_MAT);
            2'b10:   n = (SLOT_W+1)'(4 * SLOTS_PER_MAT);
            default: n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wfs_capture.sv
module wfs_capture
    import wfs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  wfs_qual_t               qual_in,
    input  logic [REGS_W-1:0]       regs_in,
    input  logic [LANES*ADDR_W-1:0] addrs_in,
    output wfs_qual_t               qual_q,
    output logic [REGS_W-1:0]       regs_q,
    output logic [LANES*ADDR_W-1:0] addrs_q
);

    localparam int LANE_BITS = MAX_MATS * REG_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '0;
        end else if (load) begin
            qual_q <= qual_in;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (load) begin
                regs_q[l*LANE_BITS +: LANE_BITS] <= regs_in[l*LANE_BITS +: LANE_BITS];
                addrs_q[l*ADDR_W +: ADDR_W]      <= addrs_in[l*ADDR_W +: ADDR_W];
            end
        end
    end

endmodule

// File: rtl/wfs_gather.sv
module wfs_gather
    import wfs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                    shape_wide,
    input  logic                    transpose,
    input  logic [REGS_W-1:0]       regs,
    input  logic [LANES*ADDR_W-1:0] addrs,
    input  logic [SLOT_W-1:0]       slot,
    output logic [ADDR_W-1:0]       row_addr,
    output logic [ROW_W-1:0]        row_data,
    output logic                    row_misaligned
);

    localparam int ALIGN_BITS    = $clog2(ROW_BYTES);
    localparam int WORDS_PER_ROW = ROW_W / REG_W;
    localparam int HALF_ROWS     = ROW_W / 16;
    localparam int BYTE_ROWS     = ROW_W / 8;
    localparam int LANES_PER_B8  = LANES / BYTE_ROWS;
    localparam int POS_W         = $clog2(SLOTS_PER_MAT);

    logic [SLOT_W-POS_W-1:0] mat;
    logic [POS_W-1:0]        pos;
    logic [ROW_W-1:0]        plain_row;
    logic [ROW_W-1:0]        col_half;
    logic [ROW_W-1:0]        col_byte;

    assign mat = slot[SLOT_W-1:POS_W];
    assign pos = slot[POS_W-1:0];

    // row-major 8x8: lanes 4*pos .. 4*pos+3 each give one whole word
    for (genvar q = 0; q < WORDS_PER_ROW; q++) begin : g_plain
        assign plain_row[q*REG_W +: REG_W] =
            regs[((int'(pos) * WORDS_PER_ROW + q) * MAX_MATS + int'(mat)) * REG_W +: REG_W];
    end

    // column-major 8x8: one 16-bit half from each row's owning lane
    for (genvar r = 0; r < HALF_ROWS; r++) begin : g_half
        logic [REG_W-1:0] src;
        assign src = regs[((r * WORDS_PER_ROW + int'(pos[POS_W-1:1])) * MAX_MATS + int'(mat)) * REG_W +: REG_W];
        assign col_half[16*r +: 16] = pos[0] ? src[31:16] : src[15:0];
    end

    // column-major 16x8: one byte from each of the 16 grid rows
    for (genvar r = 0; r < BYTE_ROWS; r++) begin : g_byte
        logic [REG_W-1:0] src;
        assign src = regs[((r * LANES_PER_B8 + int'(pos[POS_W-1])) * MAX_MATS + int'(mat)) * REG_W +: REG_W];
        assign col_byte[8*r +: 8] = src[8*int'(pos[1:0]) +: 8];
    end

    always_comb begin
        unique case ({shape_wide, transpose})
            2'b00:   row_data = plain_row;
            2'b01:   row_data = col_half;
            2'b10:   row_data = col_byte;
            2'b11:   row_data = col_byte;
            default: row_data = plain_row;
        endcase
    end

    assign row_addr       = addrs[int'(slot) * ADDR_W +: ADDR_W];
    assign row_misaligned = |row_addr[ALIGN_BITS-1:0];

endmodule

// File: rtl/wfs_ctrl.sv
module wfs_ctrl
    import wfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              legal,
    input  logic [SLOT_W:0]   n_slots,
    input  logic              misaligned,
    input  logic              wr_ready,
    output logic              load,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic              wr_valid,
    output logic              misalign_pulse,
    output logic              done,
    output logic              illegal_pulse
);

    wfs_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              illegal_q;
    logic              last_slot;
    logic              advance;

    assign last_slot = ({1'b0, slot_q} == (n_slots - 1'b1));
    assign advance   = misaligned || wr_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = legal ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:  if (advance && last_slot) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            if (state_q == ST_CHECK) begin
                slot_q    <= '0;
                illegal_q <= !legal;
            end else if (state_q == ST_ISSUE && advance && !last_slot) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    always_comb begin
        load           = 1'b0;
        busy           = 1'b1;
        wr_valid       = 1'b0;
        misalign_pulse = 1'b0;
        done           = 1'b0;
        illegal_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_CHECK: ;
            ST_ISSUE: begin
                wr_valid       = !misaligned;
                misalign_pulse = misaligned;
            end
            ST_FINISH: begin
                done          = 1'b1;
                illegal_pulse = illegal_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assign slot = slot_q;

    // R6: a rejected check leads straight to done with no write
    assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !legal) |=> (done && !wr_valid));

    // R9: busy falls right after the done pulse
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/warp_frag_store.sv
module warp_frag_store
    import wfs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    shape_16x8,
    input  logic [1:0]              count_sel,
    input  logic                    transpose,
    input  logic                    elem_8bit,
    input  logic [REGS_W-1:0]       lane_regs,
    input  logic [LANES*ADDR_W-1:0] lane_addrs,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [ROW_W-1:0]        wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err_illegal,
    output logic                    err_misalign
);

    localparam int ALIGN_BITS = $clog2(ROW_BYTES);

    wfs_qual_t               qual_in;
    wfs_qual_t               qual_q;
    logic [REGS_W-1:0]       regs_q;
    logic [LANES*ADDR_W-1:0] addrs_q;
    logic                    load;
    logic [SLOT_W-1:0]       slot;
    logic                    row_misaligned;

    assign qual_in = '{shape_wide: shape_16x8, count_code: count_sel,
                       transpose: transpose, elem_byte: elem_8bit};

    wfs_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .qual_in  (qual_in),
        .regs_in  (lane_regs),
        .addrs_in (lane_addrs),
        .qual_q   (qual_q),
        .regs_q   (regs_q),
        .addrs_q  (addrs_q)
    );

    wfs_gather #(.ADDR_W(ADDR_W)) u_gather (
        .shape_wide     (qual_q.shape_wide),
        .transpose      (qual_q.transpose),
        .regs           (regs_q),
        .addrs          (addrs_q),
        .slot           (slot),
        .row_addr       (wr_addr),
        .row_data       (wr_data),
        .row_misaligned (row_misaligned)
    );

    wfs_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .legal          (qual_legal(qual_q)),
        .n_slots        (slot_total(qual_q.count_code)),
        .misaligned     (row_misaligned),
        .wr_ready       (wr_ready),
        .load           (load),
        .busy           (busy),
        .slot           (slot),
        .wr_valid       (wr_valid),
        .misalign_pulse (err_misalign),
        .done           (done),
        .illegal_pulse  (err_illegal)
    );

    // R8: a stalled request keeps its payload
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R7: only aligned rows reach the port
    assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[ALIGN_BITS-1:0] == '0));

    // R1: a start during an operation leaves the captured qualifiers alone
    assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(qual_q));

    // R6: the illegal flag only appears together with done
    assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |-> (done && !wr_valid));

endmodule

// File: tb/warp_frag_store_tb.sv
module warp_frag_store_tb;

    localparam int ADDR_W = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 shape_16x8 = 1'b0;
    logic [1:0]           count_sel = 2'b00;
    logic                 transpose = 1'b0;
    logic                 elem_8bit = 1'b0;
    logic [32*4*32-1:0]   lane_regs = '0;
    logic [32*ADDR_W-1:0] lane_addrs = '0;
    logic                 wr_valid;
    logic                 wr_ready = 1'b0;
    logic [ADDR_W-1:0]    wr_addr;
    logic [127:0]         wr_data;
    logic                 busy, done, err_illegal, err_misalign;

    warp_frag_store #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .shape_16x8(shape_16x8),
        .count_sel(count_sel), .transpose(transpose), .elem_8bit(elem_8bit),
        .lane_regs(lane_regs), .lane_addrs(lane_addrs), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .done(done), .err_illegal(err_illegal), .err_misalign(err_misalign)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0]       regs_a [32][4];
    logic [ADDR_W-1:0] addr_a [32];
    logic [ADDR_W-1:0] qa [$];
    logic [127:0]      qd [$];
    int                exp_mis, seen_mis;
    bit                exp_illegal, illegal_seen, done_seen;
    bit                model_busy = 1'b0;
    bit                rnd_ready = 1'b0;
    bit                prev_stall = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic [127:0]      prev_data;
    logic [15:0]       lfsr = 16'hACE1;
    string             data_req = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] model_row(input bit sh, input bit tr, input int m, input int k);
        logic [127:0] d = '0;
        if (sh) begin
            for (int r = 0; r < 16; r++) d[8*r +: 8] = regs_a[2*r + k/4][m][8*(k%4) +: 8];
        end else if (tr) begin
            for (int r = 0; r < 8; r++) d[16*r +: 16] = regs_a[4*r + k/2][m][16*(k%2) +: 16];
        end else begin
            for (int c = 0; c < 8; c++) d[16*c +: 16] = regs_a[4*k + c/2][m][16*(c%2) +: 16];
        end
        return d;
    endfunction

    // ready pattern, changed away from the clock edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready = rnd_ready ? lfsr[0] : 1'b1;
    end

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == model_busy, "R1", "busy", 128'(busy), 128'(model_busy));
            if (prev_stall)
                check(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R8",
                      "stalled write changed", wr_data, prev_data);
            if (wr_valid) begin
                if (qa.size() == 0) begin
                    check(1'b0, "R6", "unexpected write", 128'(wr_addr), 128'(0));
                end else begin
                    check(wr_addr == qa[0], "R2", "address", 128'(wr_addr), 128'(qa[0]));
                    check(wr_data == qd[0], data_req, "data", wr_data, qd[0]);
                    if (wr_ready) begin
                        void'(qa.pop_front());
                        void'(qd.pop_front());
                    end
                end
            end
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            if (err_misalign) seen_mis++;
            if (done) begin
                done_seen    = 1'b1;
                illegal_seen = err_illegal;
                check(qa.size() == 0, "R9", "done before last write", 128'(qa.size()), 128'(0));
            end
            if (!model_busy && start) model_busy = 1'b1;
            else if (done)            model_busy = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_case(input bit sh, input logic [1:0] cnt, input bit tr, input bit e8,
                            input int seed, input bit rnd, input bit bad_addr, input bit poke,
                            input string req);
        bit legal;
        int nmat;
        int guard;
        for (int l = 0; l < 32; l++) begin
            for (int k = 0; k < 4; k++)
                regs_a[l][k] = {8'(l * 3 + seed), 8'(k * 41 + seed), 8'(l * 7 + k), 8'(l ^ seed)};
            addr_a[l] = ADDR_W'(((l * 29 + seed * 7) % 4096) * 16);
        end
        if (bad_addr) begin
            addr_a[3]  = addr_a[3] | 16'h0004;
            addr_a[10] = addr_a[10] | 16'h0001;
            addr_a[30] = addr_a[30] | 16'h0008;
        end
        legal = (sh ? (e8 && tr) : !e8) && (cnt != 2'b11);
        nmat  = (cnt == 2'b00) ? 1 : (cnt == 2'b01) ? 2 : 4;
        qa.delete();
        qd.delete();
        exp_mis = 0;
        if (legal) begin
            for (int m = 0; m < nmat; m++) begin
                for (int k = 0; k < 8; k++) begin
                    if (addr_a[8*m + k][3:0] != 4'h0) exp_mis++;
                    else begin
                        qa.push_back(addr_a[8*m + k]);
                        qd.push_back(model_row(sh, tr, m, k));
                    end
                end
            end
        end
        exp_illegal = !legal;
        seen_mis    = 0;
        done_seen   = 1'b0;
        data_req    = req;
        @(posedge clk); #2;
        for (int l = 0; l < 32; l++) begin
            for (int k = 0; k < 4; k++) lane_regs[(l*4 + k)*32 +: 32] = regs_a[l][k];
            lane_addrs[l*ADDR_W +: ADDR_W] = addr_a[l];
        end
        shape_16x8 = sh; count_sel = cnt; transpose = tr; elem_8bit = e8;
        rnd_ready  = rnd;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        if (poke) begin
            repeat (3) @(posedge clk);
            #2;
            lane_regs  = ~lane_regs;
            lane_addrs = '0;
            shape_16x8 = ~sh; count_sel = 2'b00;
            start = 1'b1;
            @(posedge clk); #2;
            start = 1'b0;
        end
        guard = 0;
        while (!done_seen && guard < 3000) begin
            @(posedge clk);
            guard++;
        end
        #2;
        check(done_seen, "R9", "done never seen", 128'(done_seen), 128'(1));
        check(qa.size() == 0, "R2", "writes left over", 128'(qa.size()), 128'(0));
        check(seen_mis == exp_mis, "R7", "skipped slots", 128'(seen_mis), 128'(exp_mis));
        check(illegal_seen == exp_illegal, "R6", "illegal flag", 128'(illegal_seen), 128'(exp_illegal));
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(busy == 1'b0 && wr_valid == 1'b0 && done == 1'b0, "R1", "reset outputs",
              128'({busy, wr_valid, done}), 128'(0));
        rst_n = 1'b1;
        run_case(1'b0, 2'b00, 1'b0, 1'b0, 1,  1'b0, 1'b0, 1'b0, "R3");
        run_case(1'b0, 2'b01, 1'b0, 1'b0, 5,  1'b1, 1'b0, 1'b0, "R3");
        run_case(1'b0, 2'b10, 1'b0, 1'b0, 9,  1'b1, 1'b0, 1'b0, "R3");
        run_case(1'b0, 2'b00, 1'b1, 1'b0, 13, 1'b0, 1'b0, 1'b0, "R4");
        run_case(1'b0, 2'b01, 1'b1, 1'b0, 17, 1'b1, 1'b0, 1'b0, "R4");
        run_case(1'b0, 2'b10, 1'b1, 1'b0, 21, 1'b1, 1'b0, 1'b0, "R4");
        run_case(1'b1, 2'b00, 1'b1, 1'b1, 25, 1'b0, 1'b0, 1'b0, "R5");
        run_case(1'b1, 2'b01, 1'b1, 1'b1, 29, 1'b1, 1'b0, 1'b0, "R5");
        run_case(1'b1, 2'b10, 1'b1, 1'b1, 33, 1'b1, 1'b0, 1'b0, "R5");
        // R6 rejected combinations
        run_case(1'b1, 2'b00, 1'b0, 1'b1, 37, 1'b0, 1'b0, 1'b0, "R6");
        run_case(1'b1, 2'b01, 1'b1, 1'b0, 41, 1'b0, 1'b0, 1'b0, "R6");
        run_case(1'b0, 2'b00, 1'b0, 1'b1, 45, 1'b0, 1'b0, 1'b0, "R6");
        run_case(1'b0, 2'b11, 1'b0, 1'b0, 49, 1'b0, 1'b0, 1'b0, "R6");
        // R7 misaligned lanes, with stalls and without
        run_case(1'b0, 2'b10, 1'b0, 1'b0, 53, 1'b1, 1'b1, 1'b0, "R3");
        run_case(1'b1, 2'b01, 1'b1, 1'b1, 57, 1'b0, 1'b1, 1'b0, "R5");
        // R1 start during an x4 run must be ignored
        run_case(1'b0, 2'b10, 1'b1, 1'b0, 61, 1'b1, 1'b0, 1'b1, "R4");
        run_case(1'b1, 2'b10, 1'b1, 1'b1, 65, 1'b0, 1'b0, 1'b1, "R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule